// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block drives the external memory bus of an 8-bit microcontroller core, one machine cycle at a time. A machine cycle lasts twelve oscillator clocks and is split into two six-clock halves. Each half is a bus slot. In a plain fetch cycle both slots fetch code. For each fetch the block compares the requested address, together with the level of the external-access pin, against the top of internal code space. It then either runs an external code read or leaves the bus quiet so that the core can use its internal program memory.

A slot that uses the bus first sends out an address. The low address byte goes out on a shared 8-bit address/data bus while the address-latch strobe is high, and stays on the bus for one more clock after that strobe falls, so that an external latch can capture it. The high address byte sits on its own 8-bit port. The shared bus is then released, or carries write data. Code bytes are taken in on the rising edge of the program-store strobe. A data-memory request from the core takes two machine cycles:
- **First cycle.** Its second slot sends out the data address, and the read or write strobe begins.
- **Second cycle.** Its first address-latch pulse is skipped, no program-store pulse appears, the strobe ends partway through, and the core is acknowledged in the last clock of the cycle.

Top module: `xbus_cycle_seq`

## Requirements
- R1: A machine cycle is CYC_CLKS (12) clocks: half 0 is clocks 0-5 and half 1 is clocks 6-11. The first clock edge after reset release begins clock 0 of a cycle.
- R2: In a fetch cycle, `ale` is high during clocks 0-1 of each half, which gives exactly two rising edges of `ale` per cycle. `ale` is low in every other clock.
- R3: In a slot that uses the bus, `ad_out` carries the slot address bits [7:0] with `ad_oe`=1 during clocks 0-2 of the half, so that `ale` falls while the address is still driven. `a_hi` carries address bits [15:8] of the latest slot.
- R4: When `ea`=1, a fetch address at or below INT_CODE_TOP (16'h3FFF) is internal: `psen_n` stays 1, `ad_oe` stays 0 and `code_ext`=0. Every other fetch, including every fetch made with `ea`=0, is external.
- R5: In an external fetch, `psen_n` is 0 during clocks 3-5 of the half and `ad_oe` is 0 during those clocks. `ad_in` is sampled on the edge where `psen_n` rises. `code_valid`=1 for one clock, at clock 0 of the next half, together with `code_ext` and `code_data`.
- R6: `dreq` is sampled on the edge that ends clock 11 of any cycle that is not the second cycle of a data access. When it is set, a two-cycle access (A then B) follows:
  - the half-1 address slot of cycle A carries `daddr`;
  - `ale` is absent in half 0 of cycle B;
  - `ale` therefore rises three times across A and B.
- R7: `psen_n` stays 1 in half 1 of cycle A and in all of cycle B. Across A and B there is one program-store pulse, from half 0 of A when that fetch is external.
- R8: In a read (`dwe`=0), `rd_n` is 0 from clock 9 of A through clock 4 of B and `ad_oe` is 0 during that time. `ad_in` is captured into `rdata` on the edge where `rd_n` rises, so the value is visible from clock 5 of B.
- R9: In a write (`dwe`=1), `wr_n` follows the same window as R8, and `ad_out`=`dwdata` with `ad_oe`=1 from clock 9 of A through clock 5 of B. `rd_n` stays 1 and `rdata` keeps its value.
- R10: `dack` is 1 only in clock 11 of cycle B. The cycle after B is always a fetch cycle, even when `dreq` stays 1.
- R11: While `rst_n`=0, the outputs are `ale`=0, `psen_n`=1, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `code_valid`=0 and `dack`=0.
- R12: `rd_n` and `wr_n` are never both 0. `ad_oe` is never 1 while `psen_n` or `rd_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ea | input | 1 | External-access pin level (1 = low code space is internal) |
| fetch_addr | input | 16 | Code address for the next fetch slot |
| dreq | input | 1 | Data-memory access request |
| dwe | input | 1 | 1 = write, 0 = read |
| daddr | input | 16 | Data-memory address |
| dwdata | input | 8 | Write data |
| ad_in | input | 8 | Value read from the shared bus |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Value driven onto the shared bus |
| ad_oe | output | 1 | Shared bus drive enable |
| a_hi | output | 8 | High address byte |
| code_valid | output | 1 | One-clock pulse at the end of a fetch slot |
| code_ext | output | 1 | The completed fetch was external |
| code_data | output | 8 | Last external code byte |
| rdata | output | 8 | Last data-memory read byte |
| dack | output | 1 | Data access complete |

## Verification
A wrong phase count or half flag moves every strobe edge. That shows up within one machine cycle as an address-latch or program-store pulse in the wrong clock, or as the wrong pulse count in a cycle. A wrong access-mode state shows up within the two cycles of a data access: as an extra or missing address-latch pulse, a program-store pulse during the data cycle, a strobe window shifted by a clock, or an acknowledge outside clock 11. A wrong space decision or slot flag shows up in the first fetch slot as a program-store pulse or bus drive that should not be there.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        MODE_FETCH  = 2'd0,
        MODE_DATA_A = 2'd1,
        MODE_DATA_B = 2'd2
    } bus_mode_e;

endpackage

// File: rtl/xbus_phase.sv
module xbus_phase #(
    parameter int CYC_CLKS = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    output logic                             half_o,
    output logic [$clog2(CYC_CLKS/2)-1:0]    hpos_o,
    output logic                             slot_end_o,
    output logic                             cyc_end_o
);
    localparam int HALF = CYC_CLKS / 2;
    localparam int HP_W = $clog2(HALF);

    typedef struct packed {
        logic            half;
        logic [HP_W-1:0] hpos;
    } phase_t;

    phase_t ph_d, ph_q;
    logic   slot_end;

    assign slot_end = (ph_q.hpos == HP_W'(HALF - 1));

    always_comb begin
        ph_d = ph_q;
        if (slot_end) begin
            ph_d.hpos = '0;
            ph_d.half = ~ph_q.half;
        end else begin
            ph_d.hpos = ph_q.hpos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q.half <= 1'b1;
            ph_q.hpos <= HP_W'(HALF - 1);
        end else begin
            ph_q <= ph_d;
        end
    end

    assign half_o     = ph_q.half;
    assign hpos_o     = ph_q.hpos;
    assign slot_end_o = slot_end;
    assign cyc_end_o  = slot_end & ph_q.half;

    p_half_swap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> (half_o != $past(half_o)));
    p_half_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end |=> (half_o == $past(half_o)));
    p_hpos_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(hpos_o) < HALF);

endmodule

// File: rtl/xbus_space.sv
module xbus_space #(
    parameter int                ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] INT_CODE_TOP = 16'h3FFF
) (
    input  logic              ea,
    input  logic [ADDR_W-1:0] addr,
    output logic              ext_o
);
    logic in_low_space;

    always_comb begin
        in_low_space = (addr <= INT_CODE_TOP);
        ext_o        = ~(ea & in_low_space);
    end

endmodule

// File: rtl/xbus_strobe.sv
module xbus_strobe
    import xbus_pkg::*;
#(
    parameter int CYC_CLKS = 12,
    parameter int ALE_CLKS = 2,
    parameter int DATA_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  bus_mode_e                     mode,
    input  logic                          half,
    input  logic [$clog2(CYC_CLKS/2)-1:0] hpos,
    input  logic                          slot_ale,
    input  logic                          slot_bus,
    input  logic                          slot_fetch,
    input  logic                          d_we,
    input  logic [DATA_W-1:0]             addr_lo,
    input  logic [DATA_W-1:0]             wdata,
    output logic                          ale,
    output logic                          psen_n,
    output logic                          rd_n,
    output logic                          wr_n,
    output logic                          ad_oe,
    output logic [DATA_W-1:0]             ad_out
);
    localparam int HALF = CYC_CLKS / 2;
    localparam int HP_W = $clog2(HALF);

    logic in_ale, in_addr, in_strobe_part;
    logic dstrobe, wdrive, adrive;

    always_comb begin
        in_ale         = (hpos < HP_W'(ALE_CLKS));
        in_addr        = (hpos <= HP_W'(ALE_CLKS));
        in_strobe_part = ~in_addr;
        dstrobe = ((mode == MODE_DATA_A) & half & in_strobe_part)
                | ((mode == MODE_DATA_B) & ~half & (hpos < HP_W'(HALF - 1)));
        wdrive  = d_we & (((mode == MODE_DATA_A) & half & in_strobe_part)
                        | ((mode == MODE_DATA_B) & ~half));
        adrive  = slot_ale & slot_bus & in_addr;
        ale     = slot_ale & in_ale;
        psen_n  = ~(slot_fetch & slot_bus & in_strobe_part);
        rd_n    = ~(dstrobe & ~d_we);
        wr_n    = ~(dstrobe & d_we);
        ad_oe   = adrive | wdrive;
        ad_out  = wdrive ? wdata : addr_lo;
    end

    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    p_quiet_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !psen_n) |-> !ad_oe);
    p_no_code_in_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> psen_n);
    p_ale_off_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n || !psen_n) |-> !ale);
    p_addr_after_ale_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ale) && slot_bus) |-> ad_oe);

endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
    import xbus_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter int                DATA_W       = 8,
    parameter int                CYC_CLKS     = 12,
    parameter int                ALE_CLKS     = 2,
    parameter logic [ADDR_W-1:0] INT_CODE_TOP = 16'h3FFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ea,
    input  logic [ADDR_W-1:0]    fetch_addr,
    input  logic                 dreq,
    input  logic                 dwe,
    input  logic [ADDR_W-1:0]    daddr,
    input  logic [DATA_W-1:0]    dwdata,
    input  logic [DATA_W-1:0]    ad_in,
    output logic                 ale,
    output logic                 psen_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic [DATA_W-1:0]    ad_out,
    output logic                 ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                 code_valid,
    output logic                 code_ext,
    output logic [DATA_W-1:0]    code_data,
    output logic [DATA_W-1:0]    rdata,
    output logic                 dack
);
    localparam int HALF = CYC_CLKS / 2;
    localparam int HP_W = $clog2(HALF);

    typedef struct packed {
        bus_mode_e         mode;
        logic [ADDR_W-1:0] slot_addr;
        logic              slot_ale;
        logic              slot_bus;
        logic              slot_fetch;
        logic [ADDR_W-1:0] d_addr;
        logic              d_we;
        logic [DATA_W-1:0] d_wdata;
        logic              code_valid;
        logic              code_ext;
        logic [DATA_W-1:0] code_data;
        logic [DATA_W-1:0] rdata;
        logic              dack;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic            half;
    logic [HP_W-1:0] hpos;
    logic            slot_end, cyc_end;
    logic            fetch_ext;
    logic            nxt_half;
    bus_mode_e       nxt_mode;

    xbus_phase #(.CYC_CLKS(CYC_CLKS)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_o     (half),
        .hpos_o     (hpos),
        .slot_end_o (slot_end),
        .cyc_end_o  (cyc_end)
    );

    xbus_space #(.ADDR_W(ADDR_W), .INT_CODE_TOP(INT_CODE_TOP)) u_space (
        .ea    (ea),
        .addr  (fetch_addr),
        .ext_o (fetch_ext)
    );

    always_comb begin
        st_d            = st_q;
        st_d.code_valid = 1'b0;
        st_d.dack       = 1'b0;
        nxt_half        = slot_end ? ~half : half;
        nxt_mode        = st_q.mode;

        // machine-cycle mode step
        if (cyc_end) begin
            unique case (st_q.mode)
                MODE_DATA_A: nxt_mode = MODE_DATA_B;
                MODE_DATA_B: nxt_mode = MODE_FETCH;
                default: begin
                    if (dreq) begin
                        nxt_mode     = MODE_DATA_A;
                        st_d.d_addr  = daddr;
                        st_d.d_we    = dwe;
                        st_d.d_wdata = dwdata;
                    end else begin
                        nxt_mode = MODE_FETCH;
                    end
                end
            endcase
        end
        st_d.mode = nxt_mode;

        // close the finishing slot and open the next one
        if (slot_end) begin
            if (st_q.slot_fetch) begin
                st_d.code_valid = 1'b1;
                st_d.code_ext   = st_q.slot_bus;
                if (st_q.slot_bus) begin
                    st_d.code_data = ad_in;
                end
            end
            if ((nxt_mode == MODE_DATA_B) && !nxt_half) begin
                st_d.slot_ale   = 1'b0;
                st_d.slot_bus   = 1'b0;
                st_d.slot_fetch = 1'b0;
            end else if ((nxt_mode == MODE_DATA_A) && nxt_half) begin
                st_d.slot_addr  = st_q.d_addr;
                st_d.slot_ale   = 1'b1;
                st_d.slot_bus   = 1'b1;
                st_d.slot_fetch = 1'b0;
            end else begin
                st_d.slot_addr  = fetch_addr;
                st_d.slot_ale   = 1'b1;
                st_d.slot_bus   = fetch_ext;
                st_d.slot_fetch = (nxt_mode != MODE_DATA_B);
            end
        end

        // read capture on strobe rise, acknowledge in last clock of B
        if ((st_q.mode == MODE_DATA_B) && !half && (hpos == HP_W'(HALF - 2))
                && !st_q.d_we) begin
            st_d.rdata = ad_in;
        end
        if ((st_q.mode == MODE_DATA_B) && half && (hpos == HP_W'(HALF - 2))) begin
            st_d.dack = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_FETCH, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    xbus_strobe #(
        .CYC_CLKS (CYC_CLKS),
        .ALE_CLKS (ALE_CLKS),
        .DATA_W   (DATA_W)
    ) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (st_q.mode),
        .half       (half),
        .hpos       (hpos),
        .slot_ale   (st_q.slot_ale),
        .slot_bus   (st_q.slot_bus),
        .slot_fetch (st_q.slot_fetch),
        .d_we       (st_q.d_we),
        .addr_lo    (st_q.slot_addr[DATA_W-1:0]),
        .wdata      (st_q.d_wdata),
        .ale        (ale),
        .psen_n     (psen_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .ad_oe      (ad_oe),
        .ad_out     (ad_out)
    );

    assign a_hi       = st_q.slot_addr[ADDR_W-1:DATA_W];
    assign code_valid = st_q.code_valid;
    assign code_ext   = st_q.code_ext;
    assign code_data  = st_q.code_data;
    assign rdata      = st_q.rdata;
    assign dack       = st_q.dack;

    p_a_then_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_DATA_A && cyc_end) |=> (st_q.mode == MODE_DATA_B));
    p_b_then_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_DATA_B && cyc_end) |=> (st_q.mode == MODE_FETCH));
    p_dack_in_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> (st_q.mode == MODE_DATA_B && cyc_end));
    p_code_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid);
    p_mode_only_at_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> $stable(st_q.mode));

endmodule

// File: tb/xbus_cycle_seq_tb.sv
module xbus_cycle_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {ea, fetch address, byte on bus, expected external}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 16'h0000, 8'h11, 1'b0},
        {1'b1, 16'h3FFF, 8'h22, 1'b0},
        {1'b1, 16'h4000, 8'h33, 1'b1},
        {1'b0, 16'h0000, 8'h44, 1'b1},
        {1'b0, 16'h3FFF, 8'h55, 1'b1},
        {1'b1, 16'hFFFF, 8'h66, 1'b1},
        {1'b1, 16'h1234, 8'h77, 1'b0},
        {1'b0, 16'hA55A, 8'h88, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ea = 1'b0, dreq = 1'b0, dwe = 1'b0;
    logic [15:0] fetch_addr = '0, daddr = '0;
    logic [7:0]  dwdata = '0, ad_in = '0;
    logic ale, psen_n, rd_n, wr_n, ad_oe, code_valid, code_ext, dack;
    logic [7:0] ad_out, a_hi, code_data, rdata;

    int n_chk = 0, n_bad = 0, ph = 11;
    int ale_rise = 0, psen_fall = 0, wr_low = 0, rd_low = 0;
    logic ale_prev = 1'b0, psen_prev = 1'b1;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ea(ea), .fetch_addr(fetch_addr),
        .dreq(dreq), .dwe(dwe), .daddr(daddr), .dwdata(dwdata), .ad_in(ad_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .a_hi(a_hi), .code_valid(code_valid), .code_ext(code_ext),
        .code_data(code_data), .rdata(rdata), .dack(dack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        ph = (ph + 1) % 12;
        if (ale && !ale_prev) ale_rise++;
        if (!psen_n && psen_prev) psen_fall++;
        if (!wr_n) wr_low++;
        if (!rd_n) rd_low++;
        ale_prev  = ale;
        psen_prev = psen_n;
    endtask

    task automatic clr_cnt();
        ale_rise = 0; psen_fall = 0; wr_low = 0; rd_low = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 ale", ale, 0);
        chk("R11 psen_n", psen_n, 1);
        chk("R11 rd_n", rd_n, 1);
        chk("R11 wr_n", wr_n, 1);
        chk("R11 ad_oe", ad_oe, 0);
        chk("R11 code_valid", code_valid, 0);
        chk("R11 dack", dack, 0);
        rst_n = 1'b1;
        ph = 11;

        // R1 R2 R3 R4 R5: fetch vectors
        for (int v = 0; v < NVEC; v++) begin
            ea         = VEC[v][25];
            fetch_addr = VEC[v][24:9];
            ad_in      = VEC[v][8:1];
            clr_cnt();
            for (int s = 0; s < 12; s++) begin
                step();
                if (ph == 0) begin
                    chk("R2 ale at clock 0", ale, 1);
                    chk("R3 a_hi", a_hi, int'(VEC[v][24:17]));
                    chk("R4 ad_oe in address part", ad_oe, int'(VEC[v][0]));
                    if (VEC[v][0]) chk("R3 ad_out low address", ad_out, int'(VEC[v][16:9]));
                end
                if (ph == 2) begin
                    chk("R2 ale low at clock 2", ale, 0);
                    chk("R3 address held after ale", ad_oe, int'(VEC[v][0]));
                end
                if (ph == 3) begin
                    chk("R5 psen_n", psen_n, int'(!VEC[v][0]));
                    chk("R5 bus released", ad_oe, 0);
                end
                if (ph == 6) begin
                    chk("R5 code_valid", code_valid, 1);
                    chk("R4 code_ext", code_ext, int'(VEC[v][0]));
                    if (VEC[v][0]) chk("R5 code_data", code_data, int'(VEC[v][8:1]));
                end
                if (ph == 7) chk("R5 code_valid pulse", code_valid, 0);
            end
            chk("R2 ale pulses per cycle", ale_rise, 2);
            chk("R4 psen pulses per cycle", psen_fall, VEC[v][0] ? 2 : 0);
        end

        // R6 R7 R8 R10 data read
        ea = 1'b0; fetch_addr = 16'h0100; ad_in = 8'hC7;
        dreq = 1'b1; dwe = 1'b0; daddr = 16'h8A5B;
        clr_cnt();
        for (int s = 0; s < 24; s++) begin
            step();
            if (s == 6) begin
                chk("R6 data address ale", ale, 1);
                chk("R6 data address low", ad_out, 8'h5B);
                chk("R6 data address high", a_hi, 8'h8A);
            end
            if (s == 9) begin
                chk("R8 rd_n at A9", rd_n, 0);
                chk("R8 bus released in read", ad_oe, 0);
                chk("R7 psen_n in A half1", psen_n, 1);
            end
            if (s == 12) begin
                chk("R6 ale skipped at B0", ale, 0);
                chk("R8 rd_n at B0", rd_n, 0);
                chk("R6 a_hi held", a_hi, 8'h8A);
            end
            if (s == 16) chk("R8 rd_n at B4", rd_n, 0);
            if (s == 17) begin
                chk("R8 rd_n rises at B5", rd_n, 1);
                chk("R8 rdata", rdata, 8'hC7);
            end
            if (s == 18) chk("R6 ale at B6", ale, 1);
            if (s == 21) chk("R7 psen_n at B9", psen_n, 1);
            if (s == 22) chk("R10 dack before B11", dack, 0);
            if (s == 23) begin
                chk("R10 dack at B11", dack, 1);
                dreq = 1'b0;
            end
        end
        chk("R6 ale pulses in A+B", ale_rise, 3);
        chk("R7 psen pulses in A+B", psen_fall, 1);
        chk("R8 read strobe length", rd_low, 8);
        chk("R12 wr_n idle in read", wr_low, 0);
        clr_cnt();
        for (int s = 0; s < 12; s++) begin
            step();
            if (dack) chk("R10 dack after access", dack, 0);
        end
        chk("R10 fetch follows B", psen_fall, 2);

        // R9 write, then back-to-back request R10
        fetch_addr = 16'h0200; ad_in = 8'h99;
        dreq = 1'b1; dwe = 1'b1; daddr = 16'h0042; dwdata = 8'h3C;
        clr_cnt();
        for (int s = 0; s < 24; s++) begin
            step();
            if (s == 9) begin
                chk("R9 wr_n at A9", wr_n, 0);
                chk("R9 write data driven", ad_oe, 1);
                chk("R9 write data value", ad_out, 8'h3C);
            end
            if (s == 16) chk("R9 wr_n at B4", wr_n, 0);
            if (s == 17) begin
                chk("R9 wr_n rises at B5", wr_n, 1);
                chk("R9 data held at B5", ad_oe, 1);
                chk("R9 data value at B5", ad_out, 8'h3C);
            end
            if (s == 23) begin
                chk("R10 dack write", dack, 1);
                chk("R9 rdata unchanged", rdata, 8'hC7);
                dwe = 1'b0; daddr = 16'h0043;
            end
        end
        chk("R9 rd_n idle in write", rd_low, 0);
        chk("R9 write strobe length", wr_low, 8);
        clr_cnt();
        for (int s = 0; s < 12; s++) begin
            step();
            if (s == 6) chk("R10 fetch address after B", ad_out, 8'h00);
            if (s == 9) chk("R10 no strobe after B", rd_n, 1);
        end
        chk("R10 fetch cycle between requests", psen_fall, 2);
        ad_in = 8'h5E;
        for (int s = 0; s < 24; s++) begin
            step();
            if (s == 6) chk("R6 second request address", ad_out, 8'h43);
            if (s == 17) chk("R8 second read data", rdata, 8'h5E);
            if (s == 23) begin
                chk("R10 second dack", dack, 1);
                dreq = 1'b0;
            end
        end
        finish_run();
    end

endmodule